// File: doc/BRIEF.md
# Match-Action Pipeline Stage

This block is one stage of a packet-processing pipeline. Each cycle it can take in a packet header vector (PHV) of sixteen 32-bit slots. A programmable crossbar picks four of those slots and joins them into a 128-bit lookup key. The key is compared against a small ternary match table. The entry that wins selects a wide action row. That row holds one opcode per PHV slot plus a 32-bit data word per slot. All slots are then edited in parallel, and the rewritten PHV goes on to the next stage.

Work is split over three registered steps: key build, table match and action apply. A control state machine tracks what is in flight. It has three states:

- **ST_IDLE**: no PHV is in flight. Configuration is accepted only in this state.
- **ST_FILL**: at least one PHV is in flight, but none is at the output yet.
- **ST_SEND**: a result is presented at the output.

Its transitions are:

- **accept**: ST_IDLE→ST_FILL.
- **arrive**: ST_FILL→ST_SEND.
- **refill**: ST_SEND→ST_FILL, when the output is taken and younger PHVs are still in flight.
- **empty**: ST_SEND→ST_IDLE, when the output is taken and nothing remains.
- **hold or stream**: ST_SEND→ST_SEND.

The configuration port writes crossbar selects, table entries and action rows one 32-bit word at a time.

Top module: `match_action_stage`

## Requirements
- R1: After reset, out_valid is 0 and both cfg_ready and in_ready are 1. All crossbar selects start as identity (key position k takes slot k), every table entry is invalid, and every action opcode is 0.
- R2: Key position k (0..3) occupies key bits [32k+31:32k] and carries the PHV slot named by its crossbar select. A select is written with cfg_kind=0, cfg_idx=k and cfg_wdata[3:0]=slot.
- R3: Table entry e matches when it is valid and ((key XOR value) AND mask) is zero, so a mask bit of 1 compares and 0 ignores. Value word w (kind 1) and mask word w (kind 2) cover key bits [32w+31:32w]. The valid bit is written with kind 3, cfg_wdata[0]. An invalid entry never matches.
- R4: When several entries match, the lowest index wins.
- R5: When no entry matches, action row 16 (the default row) is applied.
- R6: Action rows are numbered 0..16. Slot s uses opcode bits [4s+3:4s] of the row, written with kind 4 as word s/8. It also uses data word s, written with kind 5 and cfg_word=s. The opcodes are: 0 keep, 1 load the data word, 2 add the data word modulo 2^32, 3 copy the slot named by data bits [3:0]. Any other opcode keeps the slot.
- R7: Every slot operation reads the PHV as it entered the stage. Two copies that exchange slots therefore swap them.
- R8: A PHV accepted at clock edge k is presented with out_valid after edge k+2 when no stall occurs. One PHV can be accepted per cycle, and order is preserved.
- R9: While out_valid is 1 and out_ready is 0, out_phv holds steady and in_ready is 0.
- R10: cfg_ready is 1 exactly when no PHV is in flight. A write with cfg_we=1 while cfg_ready is 0 changes nothing. While cfg_we is 1, in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input PHV present |
| in_ready | output | 1 | Stage accepts an input PHV |
| in_phv | input | 512 | Input PHV, slot s at bits [32s+31:32s] |
| out_valid | output | 1 | Output PHV present |
| out_ready | input | 1 | Downstream takes the output PHV |
| out_phv | output | 512 | Rewritten PHV |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Target: 0 select, 1 value, 2 mask, 3 valid, 4 opcode word, 5 data word |
| cfg_idx | input | 5 | Key position, table entry or action row |
| cfg_word | input | 4 | Word index inside the target |
| cfg_wdata | input | 32 | Write data |
| cfg_ready | output | 1 | Stage is empty and configuration is accepted |

## Verification
A PHV accepted at one edge is due at the output three bench cycles after the cycle in which the driver saw in_ready. The scoreboard stamps each accepted item with a cycle count and checks that distance while back-pressure is off. Outputs are compared at the falling edge in which out_valid and out_ready are both high, which is the cycle before the transfer edge. The stall checks look at in_ready and out_phv over several falling edges after the pipeline has filled. A blocked configuration write is detected by the next PHV, whose expected value is computed from the unchanged model tables.

// File: rtl/mas_pkg.sv
package mas_pkg;
    typedef enum logic [2:0] {
        CK_KSEL   = 3'd0,
        CK_CAMVAL = 3'd1,
        CK_CAMMSK = 3'd2,
        CK_CAMEN  = 3'd3,
        CK_OPC    = 3'd4,
        CK_ADATA  = 3'd5
    } cfg_kind_e;

    typedef enum logic [3:0] {
        OP_KEEP = 4'd0,
        OP_SET  = 4'd1,
        OP_ADD  = 4'd2,
        OP_COPY = 4'd3
    } slot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_SEND
    } pipe_state_e;
endpackage

// File: rtl/mas_ctrl.sv
module mas_ctrl
    import mas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic cfg_we,
    output logic in_ready,
    output logic out_valid,
    output logic cfg_ready,
    output logic adv
);
    pipe_state_e st_q, st_d;
    logic v1_q, v2_q, v1_d, v2_d, fire;

    // Advance/handshake and next state
    always_comb begin
        adv      = !(st_q == ST_SEND && !out_ready);
        in_ready = adv && !cfg_we;
        fire     = in_valid && in_ready;
        v1_d     = adv ? fire : v1_q;
        v2_d     = adv ? v1_q : v2_q;
        st_d     = st_q;
        unique case (st_q)
            ST_IDLE: if (fire) st_d = ST_FILL;             // accept
            ST_FILL: if (v2_q) st_d = ST_SEND;             // arrive
            ST_SEND: begin
                if (adv) begin
                    if (v2_q)              st_d = ST_SEND; // stream
                    else if (v1_q || fire) st_d = ST_FILL; // refill
                    else                   st_d = ST_IDLE; // empty
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= v1_d;
            v2_q <= v2_d;
        end
    end

    // Outputs
    always_comb begin
        out_valid = (st_q == ST_SEND);
        cfg_ready = (st_q == ST_IDLE);
    end
endmodule

// File: rtl/mas_keyxbar.sv
module mas_keyxbar
    import mas_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int SW    = 32,
    parameter int NKEY  = 4,
    parameter int EIW   = 5,
    localparam int SIW  = $clog2(NSLOT),
    localparam int PW   = NSLOT * SW,
    localparam int KW   = NKEY * SW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           cfg_ok,
    input  logic [2:0]     cfg_kind,
    input  logic [EIW-1:0] cfg_idx,
    input  logic [SIW-1:0] cfg_sel,
    input  logic [PW-1:0]  in_phv,
    output logic [PW-1:0]  phv1,
    output logic [KW-1:0]  key1
);
    logic [SIW-1:0] ksel_q [NKEY];
    logic [KW-1:0]  key_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NKEY; k++) ksel_q[k] <= SIW'(k);
        end else if (cfg_ok && cfg_kind == CK_KSEL) begin
            for (int k = 0; k < NKEY; k++)
                if (cfg_idx == EIW'(k)) ksel_q[k] <= cfg_sel;
        end
    end

    generate
        for (genvar k = 0; k < NKEY; k++) begin : g_key
            assign key_d[k*SW +: SW] = in_phv[ksel_q[k]*SW +: SW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phv1 <= '0;
            key1 <= '0;
        end else if (adv) begin
            phv1 <= in_phv;
            key1 <= key_d;
        end
    end
endmodule

// File: rtl/mas_tcam.sv
module mas_tcam
    import mas_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int SW    = 32,
    parameter int NKEY  = 4,
    parameter int NENT  = 16,
    parameter int EIW   = 5,
    parameter int CWW   = 4,
    localparam int PW   = NSLOT * SW,
    localparam int KW   = NKEY * SW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           cfg_ok,
    input  logic [2:0]     cfg_kind,
    input  logic [EIW-1:0] cfg_idx,
    input  logic [CWW-1:0] cfg_word,
    input  logic [SW-1:0]  cfg_wdata,
    input  logic [KW-1:0]  key1,
    input  logic [PW-1:0]  phv1,
    output logic [PW-1:0]  phv2,
    output logic [EIW-1:0] sel2
);
    logic [KW-1:0]   val_q [NENT];
    logic [KW-1:0]   msk_q [NENT];
    logic [NENT-1:0] en_q;
    logic [EIW-1:0]  hit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                val_q[e] <= '0;
                msk_q[e] <= '0;
            end
            en_q <= '0;
        end else if (cfg_ok) begin
            for (int e = 0; e < NENT; e++) begin
                if (cfg_idx == EIW'(e)) begin
                    for (int w = 0; w < NKEY; w++) begin
                        if (cfg_word == CWW'(w)) begin
                            if (cfg_kind == CK_CAMVAL) val_q[e][w*SW +: SW] <= cfg_wdata;
                            if (cfg_kind == CK_CAMMSK) msk_q[e][w*SW +: SW] <= cfg_wdata;
                        end
                    end
                    if (cfg_kind == CK_CAMEN) en_q[e] <= cfg_wdata[0];
                end
            end
        end
    end

    // Lowest index wins: scan from the top down
    always_comb begin
        hit_idx = EIW'(NENT);
        for (int e = NENT - 1; e >= 0; e--)
            if (en_q[e] && (((key1 ^ val_q[e]) & msk_q[e]) == '0))
                hit_idx = EIW'(e);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phv2 <= '0;
            sel2 <= '0;
        end else if (adv) begin
            phv2 <= phv1;
            sel2 <= hit_idx;
        end
    end
endmodule

// File: rtl/mas_action.sv
module mas_action
    import mas_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int SW    = 32,
    parameter int NENT  = 16,
    parameter int OPW   = 4,
    parameter int EIW   = 5,
    parameter int CWW   = 4,
    localparam int SIW  = $clog2(NSLOT),
    localparam int PW   = NSLOT * SW,
    localparam int OPB  = NSLOT * OPW,
    localparam int OPWD = OPB / SW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           cfg_ok,
    input  logic [2:0]     cfg_kind,
    input  logic [EIW-1:0] cfg_idx,
    input  logic [CWW-1:0] cfg_word,
    input  logic [SW-1:0]  cfg_wdata,
    input  logic [PW-1:0]  phv2,
    input  logic [EIW-1:0] sel2,
    output logic [PW-1:0]  phv3
);
    logic [OPB-1:0] op_q  [NENT+1];
    logic [PW-1:0]  dat_q [NENT+1];
    logic [OPB-1:0] row_op;
    logic [PW-1:0]  row_dat;
    logic [PW-1:0]  res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e <= NENT; e++) begin
                op_q[e]  <= '0;
                dat_q[e] <= '0;
            end
        end else if (cfg_ok) begin
            for (int e = 0; e <= NENT; e++) begin
                if (cfg_idx == EIW'(e)) begin
                    for (int w = 0; w < OPWD; w++)
                        if (cfg_kind == CK_OPC && cfg_word == CWW'(w))
                            op_q[e][w*SW +: SW] <= cfg_wdata;
                    for (int w = 0; w < NSLOT; w++)
                        if (cfg_kind == CK_ADATA && cfg_word == CWW'(w))
                            dat_q[e][w*SW +: SW] <= cfg_wdata;
                end
            end
        end
    end

    assign row_op  = op_q[sel2];
    assign row_dat = dat_q[sel2];

    // One editor per slot; each reads only the incoming PHV
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            logic [OPW-1:0] nib;
            logic [SW-1:0]  d;
            logic [SIW-1:0] src;
            assign nib = row_op[s*OPW +: OPW];
            assign d   = row_dat[s*SW +: SW];
            assign src = d[SIW-1:0];
            always_comb begin
                case (nib)
                    OP_SET:  res[s*SW +: SW] = d;
                    OP_ADD:  res[s*SW +: SW] = phv2[s*SW +: SW] + d;
                    OP_COPY: res[s*SW +: SW] = phv2[src*SW +: SW];
                    default: res[s*SW +: SW] = phv2[s*SW +: SW];
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phv3 <= '0;
        else if (adv) phv3 <= res;
    end
endmodule

// File: rtl/match_action_stage.sv
module match_action_stage
    import mas_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int SW    = 32,
    parameter int NKEY  = 4,
    parameter int NENT  = 16,
    parameter int OPW   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [NSLOT*SW-1:0]           in_phv,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [NSLOT*SW-1:0]           out_phv,
    input  logic                          cfg_we,
    input  logic [2:0]                    cfg_kind,
    input  logic [$clog2(NENT+1)-1:0]     cfg_idx,
    input  logic [$clog2(NSLOT)-1:0]      cfg_word,
    input  logic [SW-1:0]                 cfg_wdata,
    output logic                          cfg_ready
);
    localparam int PW  = NSLOT * SW;
    localparam int KW  = NKEY * SW;
    localparam int EIW = $clog2(NENT + 1);
    localparam int CWW = $clog2(NSLOT);
    localparam int SIW = $clog2(NSLOT);

    logic           adv, cfg_ok;
    logic [PW-1:0]  phv1, phv2;
    logic [KW-1:0]  key1;
    logic [EIW-1:0] sel2;

    assign cfg_ok = cfg_we && cfg_ready;

    mas_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .cfg_we(cfg_we), .in_ready(in_ready), .out_valid(out_valid),
        .cfg_ready(cfg_ready), .adv(adv)
    );

    mas_keyxbar #(.NSLOT(NSLOT), .SW(SW), .NKEY(NKEY), .EIW(EIW)) u_key (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cfg_ok(cfg_ok), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_sel(cfg_wdata[SIW-1:0]), .in_phv(in_phv),
        .phv1(phv1), .key1(key1)
    );

    mas_tcam #(.NSLOT(NSLOT), .SW(SW), .NKEY(NKEY), .NENT(NENT), .EIW(EIW), .CWW(CWW)) u_tcam (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cfg_ok(cfg_ok), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .key1(key1), .phv1(phv1), .phv2(phv2), .sel2(sel2)
    );

    mas_action #(.NSLOT(NSLOT), .SW(SW), .NENT(NENT), .OPW(OPW), .EIW(EIW), .CWW(CWW)) u_act (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cfg_ok(cfg_ok), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .phv2(phv2), .sel2(sel2), .phv3(out_phv)
    );
endmodule

// File: rtl/mas_checker.sv
module mas_checker #(
    parameter int PW = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_phv,
    input logic          cfg_we,
    input logic          cfg_ready
);
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 !(out_valid && !out_ready) ##1 !(out_valid && !out_ready)
        |=> out_valid);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_phv)));

    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_cfg_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> !out_valid);

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !cfg_ready);

    p_cfg_we_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> !in_ready);
endmodule

bind match_action_stage mas_checker #(.PW(NSLOT*SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_phv(out_phv),
    .cfg_we(cfg_we), .cfg_ready(cfg_ready)
);

// File: tb/match_action_stage_bench.sv
`timescale 1ns/1ps
module match_action_stage_bench;
    localparam int NS = 16;
    localparam int PW = NS * 32;
    localparam int KW = 128;
    localparam logic [2:0] K_SEL = 3'd0, K_VAL = 3'd1, K_MSK = 3'd2,
                           K_EN = 3'd3, K_OPC = 3'd4, K_DAT = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1, cfg_we = 1'b0;
    logic [PW-1:0] in_phv = '0;
    logic [2:0] cfg_kind = '0;
    logic [4:0] cfg_idx = '0;
    logic [3:0] cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic in_ready, out_valid, cfg_ready;
    logic [PW-1:0] out_phv;

    always #2 clk = ~clk;

    match_action_stage u_match_action_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_phv(in_phv), .out_valid(out_valid), .out_ready(out_ready),
        .out_phv(out_phv), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .cfg_ready(cfg_ready)
    );

    // Reference tables
    logic [3:0]    m_ksel [4];
    logic [KW-1:0] m_val [16];
    logic [KW-1:0] m_msk [16];
    logic [15:0]   m_en;
    logic [63:0]   m_op  [17];
    logic [PW-1:0] m_dat [17];

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit lat_on = 1'b0;
    logic [PW-1:0] exp_q[$];
    string tag_q[$];
    int stamp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PW-1:0] model(input logic [PW-1:0] p);
        logic [KW-1:0] key;
        logic [PW-1:0] r;
        logic [31:0] d;
        int hit;
        for (int k = 0; k < 4; k++) key[k*32 +: 32] = p[m_ksel[k]*32 +: 32];
        hit = 16;
        for (int e = 15; e >= 0; e--)
            if (m_en[e] && (((key ^ m_val[e]) & m_msk[e]) == '0)) hit = e;
        r = p;
        for (int s = 0; s < NS; s++) begin
            d = m_dat[hit][s*32 +: 32];
            case (m_op[hit][s*4 +: 4])
                4'd1: r[s*32 +: 32] = d;
                4'd2: r[s*32 +: 32] = p[s*32 +: 32] + d;
                4'd3: r[s*32 +: 32] = p[d[3:0]*32 +: 32];
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] k, input int idx, input int word,
                       input logic [31:0] v, input bit take);
        cfg_kind = k; cfg_idx = 5'(idx); cfg_word = 4'(word); cfg_wdata = v; cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (take) begin
            case (k)
                K_SEL: m_ksel[idx] = v[3:0];
                K_VAL: m_val[idx][word*32 +: 32] = v;
                K_MSK: m_msk[idx][word*32 +: 32] = v;
                K_EN:  m_en[idx] = v[0];
                K_OPC: m_op[idx][word*32 +: 32] = v;
                K_DAT: m_dat[idx][word*32 +: 32] = v;
                default: ;
            endcase
        end
    endtask

    task automatic set_op(input int e, input int s, input logic [3:0] op, input logic [31:0] d);
        logic [63:0] t;
        t = m_op[e];
        t[s*4 +: 4] = op;
        cfg(K_OPC, e, s / 8, t[(s/8)*32 +: 32], 1'b1);
        cfg(K_DAT, e, s, d, 1'b1);
    endtask

    task automatic send(input logic [PW-1:0] p, input string tag);
        exp_q.push_back(model(p));
        tag_q.push_back(tag);
        in_phv = p; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        stamp_q.push_back(cyc);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        forever begin
            @(negedge clk);
            if (exp_q.size() == 0 && cfg_ready) break;
        end
        @(posedge clk); #1;
    endtask

    function automatic logic [PW-1:0] base();
        logic [PW-1:0] p;
        for (int i = 0; i < NS; i++) p[i*32 +: 32] = {8'(i), 24'hC0FFEE};
        return p;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected output", out_phv, '0);
            end else begin
                logic [PW-1:0] e;
                string t;
                int st;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                st = stamp_q.pop_front();
                check(out_phv === e, t, out_phv, e);
                if (lat_on) check((cyc - st) == 3, "R8 latency", PW'(cyc - st), PW'(3));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] p, held;
        int c0;
        for (int k = 0; k < 4; k++) m_ksel[k] = 4'(k);
        for (int e = 0; e < 16; e++) begin m_val[e] = '0; m_msk[e] = '0; end
        for (int e = 0; e < 17; e++) begin m_op[e] = '0; m_dat[e] = '0; end
        m_en = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", PW'(out_valid), PW'(0));
        check(cfg_ready == 1'b1, "R1 cfg_ready", PW'(cfg_ready), PW'(1));
        check(in_ready == 1'b1, "R1 in_ready", PW'(in_ready), PW'(1));
        @(posedge clk); #1;

        send(base(), "R5 reset default row keeps all slots");
        drain();

        // Crossbar: key = slots 3,7,0,12
        cfg(K_SEL, 0, 0, 32'd3, 1'b1);
        cfg(K_SEL, 1, 0, 32'd7, 1'b1);
        cfg(K_SEL, 2, 0, 32'd0, 1'b1);
        cfg(K_SEL, 3, 0, 32'd12, 1'b1);
        set_op(16, 15, 4'd2, 32'd1);
        // Entry 2: exact match on key word 0
        cfg(K_VAL, 2, 0, 32'hAAAA0001, 1'b1);
        cfg(K_MSK, 2, 0, 32'hFFFFFFFF, 1'b1);
        cfg(K_EN, 2, 0, 32'd1, 1'b1);
        set_op(2, 0, 4'd1, 32'h11111111);
        set_op(2, 1, 4'd2, 32'd5);
        set_op(2, 2, 4'd3, 32'd4);
        set_op(2, 4, 4'd3, 32'd2);
        set_op(2, 5, 4'd3, 32'd1);
        set_op(2, 8, 4'd7, 32'h5555);
        // Entry 5: upper half of key word 1
        cfg(K_VAL, 5, 1, 32'h12340000, 1'b1);
        cfg(K_MSK, 5, 1, 32'hFFFF0000, 1'b1);
        cfg(K_EN, 5, 0, 32'd1, 1'b1);
        set_op(5, 6, 4'd1, 32'h66);
        // Entry 6: catch-all pattern but left invalid
        set_op(6, 7, 4'd1, 32'h77);

        p = base(); p[3*32 +: 32] = 32'hAAAA0001; p[1*32 +: 32] = 32'hFFFFFFFE;
        send(p, "R6 set/add-wrap/copy/undefined-op, R7 swap via entry 2");
        p = base(); p[0*32 +: 32] = 32'hAAAA0001;
        send(p, "R2 crossbar reads slot 3 not slot 0");
        p = base(); p[7*32 +: 32] = 32'h1234ABCD;
        send(p, "R3 masked bits ignored");
        p = base(); p[7*32 +: 32] = 32'h1235ABCD;
        send(p, "R3 compared bit differs, invalid entry 6 ignored");
        p = base(); p[3*32 +: 32] = 32'hAAAA0001; p[7*32 +: 32] = 32'h1234FFFF;
        send(p, "R4 entry 2 beats entry 5");
        drain();

        cfg(K_EN, 9, 0, 32'd1, 1'b1);
        set_op(9, 9, 4'd1, 32'h99);
        send(base(), "R4 catch-all entry 9 wins over default row");
        p = base(); p[3*32 +: 32] = 32'hAAAA0001;
        send(p, "R4 entry 2 beats catch-all 9");
        drain();

        // Back-to-back stream
        lat_on = 1'b1;
        c0 = cyc;
        for (int i = 0; i < 6; i++) begin
            p = base(); p[10*32 +: 32] = 32'(i * 7);
            if (i % 2 == 0) p[3*32 +: 32] = 32'hAAAA0001;
            send(p, "R8 stream order");
        end
        check((cyc - c0) == 6, "R8 one accept per cycle", PW'(cyc - c0), PW'(6));
        drain();
        lat_on = 1'b0;

        // Back-pressure
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            p = base(); p[11*32 +: 32] = 32'(100 + i);
            send(p, "R9 order after stall");
        end
        @(negedge clk);
        check(out_valid && !in_ready, "R9 stalled output blocks input",
              PW'({out_valid, in_ready}), PW'(2'b10));
        held = out_phv;
        check(cfg_ready == 1'b0, "R10 cfg_ready low while busy", PW'(cfg_ready), PW'(0));
        @(posedge clk); #1;
        cfg(K_DAT, 9, 9, 32'hDEAD, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_phv === held && out_valid, "R9 output held", out_phv, held);
        check(out_phv === exp_q[0], "R9 held value is oldest item", out_phv, exp_q[0]);
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();
        send(base(), "R10 blocked write left entry 9 data unchanged");
        drain();

        // cfg_we blocks input
        cfg_kind = K_DAT; cfg_idx = 5'd9; cfg_word = 4'd9; cfg_wdata = 32'h99;
        cfg_we = 1'b1; in_phv = base(); in_valid = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0, "R10 cfg_we blocks input", PW'(in_ready), PW'(0));
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && cfg_ready == 1'b1, "R10 no PHV taken during cfg write",
              PW'({out_valid, cfg_ready}), PW'(2'b01));
        @(posedge clk); #1;

        check(exp_q.size() == 0, "R8 scoreboard empty", PW'(exp_q.size()), PW'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule